// File: doc/BRIEF.md
# PCIe Core Reset and Clock Sequencer

This block walks a PCIe controller and its PHY into and out of reset by issuing single-bit updates to a small set of general-purpose control bits. Two commands start it. The shutdown command (`start_assert`) puts the link into a safe state for reconfiguration. It first checks whether earlier firmware left the link running. If so, it forces the link training state machine back to its detect state through a read-modify-write of the port-force register, and then turns link training off. After that it powers the PHY down and gates the reference clock. The bring-up command (`start_deassert`) powers the PHY up and waits, so that the PHY's internally synchronised reset stays long enough. It then enables the reference clock, waits for the clocks to settle and, if the board has one, pulses the endpoint reset pin.

Control-bit updates leave the block as a one-cycle write strobe that carries a field code and a value. The port-force register update leaves it as a one-cycle write strobe that carries a full 32-bit word. The block carries no data stream, so every pin is a plain level or a one-cycle strobe and none of them uses valid/ready flow control. All wait times are parameters counted in clock cycles. `busy` is high from the cycle after a command is accepted up to and including the cycle in which `done` pulses.

Top module: `pcie_rst_sequencer`

## Requirements
- R1: While reset is applied and afterwards with no command, `busy`, `done`, `ctl_wr` and `pfr_wr` are 0, `pfr_wdata` is 0 and `perst_o` sits at its inactive level.
- R2: On an accepted shutdown command, if `refclk_en_rb` and `ltssm_en_rb` are both 1 in the cycle after acceptance, the next cycle issues `pfr_wr`. Its `pfr_wdata` equals `pfr_rdata` with bits 21:16 cleared and bit 15 set, and all other bits are unchanged.
- R3: The cycle right after that port-force write clears link training (`ctl_field` = 0, `ctl_val` = 0). If either readback is 0, the shutdown issues neither the port-force write nor the link-training write.
- R4: The shutdown then sets PHY power-down (`ctl_field` = 2, `ctl_val` = 1), and in the following cycle clears reference-clock enable (`ctl_field` = 1, `ctl_val` = 0).
- R5: On an accepted bring-up command, the next cycle clears PHY power-down. Exactly T_REFCLK idle cycles follow, and then reference-clock enable is set.
- R6: After the reference-clock enable write, the block waits exactly T_STABLE cycles before the reset-pin pulse, or before `done` when there is no pin.
- R7: With PERST_PRESENT = 1, `perst_o` is at its active level (high if PERST_ACTIVE_HIGH = 1, low otherwise) for exactly T_PERST cycles, and `done` follows in the next cycle.
- R8: With PERST_PRESENT = 0, `perst_o` never leaves its inactive level, and `done` follows the settle wait immediately.
- R9: `done` is high for exactly one cycle, and that cycle is the last one of each phase.
- R10: A command is accepted only when `busy` is 0. Commands that arrive while busy have no effect. If both commands arrive together, the shutdown wins.
- R11: At most one of `ctl_wr` and `pfr_wr` is high in any cycle. The field codes are 0 = link-training enable, 1 = reference-clock enable, 2 = PHY power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_assert | input | 1 | Start the shutdown phase |
| start_deassert | input | 1 | Start the bring-up phase |
| refclk_en_rb | input | 1 | Readback of reference-clock enable |
| ltssm_en_rb | input | 1 | Readback of link-training enable |
| pfr_rdata | input | 32 | Current port-force register value |
| ctl_wr | output | 1 | Control-bit write strobe |
| ctl_field | output | 2 | Control bit selected by the write |
| ctl_val | output | 1 | Value written to the selected bit |
| pfr_wr | output | 1 | Port-force register write strobe |
| pfr_wdata | output | 32 | Port-force word to write (0 when not writing) |
| perst_o | output | 1 | Endpoint reset pin |
| busy | output | 1 | A phase is in progress |
| done | output | 1 | One-cycle pulse at the end of a phase |

## Verification
The shutdown phase is run with all four combinations of the two readbacks. Only both-set must give the port-force write followed by the link-training write; the other three must skip straight to power-down. Several port-force read words (mixed bits, all ones, all zeros) separate a correct field clear and force-bit set from a mask that is wrong or shifted. The bring-up phase is checked cycle by cycle against a timeline model on an instance with a reset pin and one without, which pins down each wait length and the pulse polarity. Commands issued mid-phase, held high across a phase, or raised together show that acceptance happens only when idle and that the shutdown takes priority.

// File: rtl/pcie_rstseq_pkg.sv
package pcie_rstseq_pkg;

  typedef enum logic [1:0] {
    FLD_LTSSM  = 2'd0,
    FLD_REFCLK = 2'd1,
    FLD_PHYPD  = 2'd2
  } ctl_field_e;

  typedef struct packed {
    logic       wr;
    ctl_field_e field;
    logic       val;
  } ctl_cmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_CHECK,
    ST_A_FORCE,
    ST_A_LTOFF,
    ST_A_PDON,
    ST_A_REFOFF,
    ST_D_PDOFF,
    ST_D_WREF,
    ST_D_REFON,
    ST_D_WSTB,
    ST_D_PERST,
    ST_DONE
  } seq_state_e;

  localparam int unsigned PFR_W         = 32;
  localparam int unsigned LINK_FIELD_LSB = 16;
  localparam int unsigned LINK_FIELD_W   = 6;
  localparam int unsigned FORCE_BIT      = 15;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt;

  assign hit = run && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/rstseq_force_merge.sv
module rstseq_force_merge #(
  parameter int unsigned DW      = 32,
  parameter int unsigned FLD_LSB = 16,
  parameter int unsigned FLD_W   = 6,
  parameter int unsigned FBIT    = 15
) (
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] wr_word
);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b >= FLD_LSB && b < FLD_LSB + FLD_W) begin : g_clr
      assign wr_word[b] = 1'b0;
    end else if (b == FBIT) begin : g_set
      assign wr_word[b] = 1'b1;
    end else begin : g_keep
      assign wr_word[b] = rd_word[b];
    end
  end

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import pcie_rstseq_pkg::*;
#(
  parameter int unsigned T_REFCLK      = 500,
  parameter int unsigned T_STABLE      = 10000,
  parameter int unsigned T_PERST       = 5000000,
  parameter bit          PERST_PRESENT = 1'b1,
  parameter int unsigned CW            = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_assert,
  input  logic          start_deassert,
  input  logic          refclk_en_rb,
  input  logic          ltssm_en_rb,
  input  logic          tmr_hit,
  output logic          tmr_run,
  output logic [CW-1:0] tmr_limit,
  output ctl_cmd_t      cmd,
  output logic          pfr_wr,
  output logic          perst_next,
  output logic          busy,
  output logic          done
);

  seq_state_e state, state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: begin
        if (start_assert)        state_n = ST_A_CHECK;
        else if (start_deassert) state_n = ST_D_PDOFF;
      end
      ST_A_CHECK:  state_n = (refclk_en_rb && ltssm_en_rb) ? ST_A_FORCE : ST_A_PDON;
      ST_A_FORCE:  state_n = ST_A_LTOFF;
      ST_A_LTOFF:  state_n = ST_A_PDON;
      ST_A_PDON:   state_n = ST_A_REFOFF;
      ST_A_REFOFF: state_n = ST_DONE;
      ST_D_PDOFF:  state_n = ST_D_WREF;
      ST_D_WREF:   if (tmr_hit) state_n = ST_D_REFON;
      ST_D_REFON:  state_n = ST_D_WSTB;
      ST_D_WSTB:   if (tmr_hit) state_n = PERST_PRESENT ? ST_D_PERST : ST_DONE;
      ST_D_PERST:  if (tmr_hit) state_n = ST_DONE;
      ST_DONE:     state_n = ST_IDLE;
      default:     state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  always_comb begin
    cmd       = '{wr: 1'b0, field: FLD_LTSSM, val: 1'b0};
    pfr_wr    = 1'b0;
    tmr_run   = 1'b0;
    tmr_limit = CW'(T_REFCLK);
    unique case (state)
      ST_A_FORCE:  pfr_wr = 1'b1;
      ST_A_LTOFF:  cmd = '{wr: 1'b1, field: FLD_LTSSM,  val: 1'b0};
      ST_A_PDON:   cmd = '{wr: 1'b1, field: FLD_PHYPD,  val: 1'b1};
      ST_A_REFOFF: cmd = '{wr: 1'b1, field: FLD_REFCLK, val: 1'b0};
      ST_D_PDOFF:  cmd = '{wr: 1'b1, field: FLD_PHYPD,  val: 1'b0};
      ST_D_REFON:  cmd = '{wr: 1'b1, field: FLD_REFCLK, val: 1'b1};
      ST_D_WREF: begin
        tmr_run   = 1'b1;
        tmr_limit = CW'(T_REFCLK);
      end
      ST_D_WSTB: begin
        tmr_run   = 1'b1;
        tmr_limit = CW'(T_STABLE);
      end
      ST_D_PERST: begin
        tmr_run   = 1'b1;
        tmr_limit = CW'(T_PERST);
      end
      default: ;
    endcase
  end

  assign perst_next = (state_n == ST_D_PERST);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);

endmodule

// File: rtl/pcie_rst_sequencer.sv
module pcie_rst_sequencer
  import pcie_rstseq_pkg::*;
#(
  parameter int unsigned T_REFCLK          = 500,
  parameter int unsigned T_STABLE          = 10000,
  parameter int unsigned T_PERST           = 5000000,
  parameter bit          PERST_PRESENT     = 1'b1,
  parameter bit          PERST_ACTIVE_HIGH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_assert,
  input  logic        start_deassert,
  input  logic        refclk_en_rb,
  input  logic        ltssm_en_rb,
  input  logic [31:0] pfr_rdata,
  output logic        ctl_wr,
  output logic [1:0]  ctl_field,
  output logic        ctl_val,
  output logic        pfr_wr,
  output logic [31:0] pfr_wdata,
  output logic        perst_o,
  output logic        busy,
  output logic        done
);

  localparam int unsigned T_MAX = max3(T_REFCLK, T_STABLE, T_PERST);
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  logic          tmr_run, tmr_hit, perst_next, perst_q;
  logic [CW-1:0] tmr_limit;
  ctl_cmd_t      cmd;
  logic [31:0]   merged;

  rstseq_fsm #(
    .T_REFCLK     (T_REFCLK),
    .T_STABLE     (T_STABLE),
    .T_PERST      (T_PERST),
    .PERST_PRESENT(PERST_PRESENT),
    .CW           (CW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_assert  (start_assert),
    .start_deassert(start_deassert),
    .refclk_en_rb  (refclk_en_rb),
    .ltssm_en_rb   (ltssm_en_rb),
    .tmr_hit       (tmr_hit),
    .tmr_run       (tmr_run),
    .tmr_limit     (tmr_limit),
    .cmd           (cmd),
    .pfr_wr        (pfr_wr),
    .perst_next    (perst_next),
    .busy          (busy),
    .done          (done)
  );

  rstseq_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tmr_run),
    .limit(tmr_limit),
    .hit  (tmr_hit)
  );

  rstseq_force_merge #(
    .DW     (PFR_W),
    .FLD_LSB(LINK_FIELD_LSB),
    .FLD_W  (LINK_FIELD_W),
    .FBIT   (FORCE_BIT)
  ) u_merge (
    .rd_word(pfr_rdata),
    .wr_word(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) perst_q <= 1'b0;
    else        perst_q <= perst_next;
  end

  assign perst_o   = PERST_ACTIVE_HIGH ? perst_q : ~perst_q;
  assign ctl_wr    = cmd.wr;
  assign ctl_field = cmd.field;
  assign ctl_val   = cmd.val;
  assign pfr_wdata = pfr_wr ? merged : '0;

endmodule

// File: rtl/pcie_rst_sequencer_chk.sv
module pcie_rst_sequencer_chk #(
  parameter bit ACT_HIGH = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [1:0]  ctl_field,
  input logic        ctl_val,
  input logic        pfr_wr,
  input logic [31:0] pfr_wdata,
  input logic        perst_o,
  input logic        busy,
  input logic        done
);

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && pfr_wr)); // R11

  AST_FORCE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    pfr_wr |-> (pfr_wdata[21:16] == 6'd0) && pfr_wdata[15]); // R2

  AST_FORCE_THEN_LTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    pfr_wr |=> ctl_wr && (ctl_field == 2'd0) && !ctl_val); // R3

  AST_PD_THEN_REFOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_field == 2'd2 && ctl_val) |=> ctl_wr && (ctl_field == 2'd1) && !ctl_val); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ctl_wr && !pfr_wr && !done); // R10

  AST_PERST_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (perst_o == ACT_HIGH) |-> busy); // R7

endmodule

bind pcie_rst_sequencer pcie_rst_sequencer_chk #(.ACT_HIGH(PERST_ACTIVE_HIGH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_wr   (ctl_wr),
  .ctl_field(ctl_field),
  .ctl_val  (ctl_val),
  .pfr_wr   (pfr_wr),
  .pfr_wdata(pfr_wdata),
  .perst_o  (perst_o),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_pcie_rst_sequencer.sv
module tb_pcie_rst_sequencer;

  localparam int TR = 4;
  localparam int TS = 6;
  localparam int TP = 5;

  typedef struct packed {
    logic        busy;
    logic        done;
    logic        ctl_wr;
    logic [1:0]  fld;
    logic        val;
    logic        pfr_wr;
    logic        perst;
    logic [31:0] wdata;
  } vec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_assert = 1'b0, start_deassert = 1'b0;
  logic refclk_en_rb = 1'b0, ltssm_en_rb = 1'b0;
  logic [31:0] pfr_rdata = 32'h0;

  vec_t act [2];
  int checks = 0;
  int fails  = 0;
  bit in_reset = 1'b1;
  bit finished = 1'b0;

  // kind: 0 idle, 1 shutdown with live link, 2 shutdown without, 3 bring-up
  int kind [2];
  int pos  [2];

  always #10 clk = ~clk;

  pcie_rst_sequencer #(.T_REFCLK(TR), .T_STABLE(TS), .T_PERST(TP),
    .PERST_PRESENT(1'b1), .PERST_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start_assert(start_assert), .start_deassert(start_deassert),
    .refclk_en_rb(refclk_en_rb), .ltssm_en_rb(ltssm_en_rb), .pfr_rdata(pfr_rdata),
    .ctl_wr(act[0].ctl_wr), .ctl_field(act[0].fld), .ctl_val(act[0].val),
    .pfr_wr(act[0].pfr_wr), .pfr_wdata(act[0].wdata), .perst_o(act[0].perst),
    .busy(act[0].busy), .done(act[0].done));

  pcie_rst_sequencer #(.T_REFCLK(TR), .T_STABLE(TS), .T_PERST(TP),
    .PERST_PRESENT(1'b0), .PERST_ACTIVE_HIGH(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .start_assert(start_assert), .start_deassert(start_deassert),
    .refclk_en_rb(refclk_en_rb), .ltssm_en_rb(ltssm_en_rb), .pfr_rdata(pfr_rdata),
    .ctl_wr(act[1].ctl_wr), .ctl_field(act[1].fld), .ctl_val(act[1].val),
    .pfr_wr(act[1].pfr_wr), .pfr_wdata(act[1].wdata), .perst_o(act[1].perst),
    .busy(act[1].busy), .done(act[1].done));

  function automatic bit has_pin(int i);
    return (i == 0);
  endfunction

  function automatic bit act_high(int i);
    return (i == 0);
  endfunction

  function automatic int phase_len(int k, int i);
    case (k)
      1: return 6;
      2: return 4;
      3: return TR + TS + 3 + (has_pin(i) ? TP : 0);
      default: return 0;
    endcase
  endfunction

  function automatic vec_t model(int k, int p, int i);
    vec_t v;
    int   plen;
    v = '0;
    v.perst = !act_high(i);
    if (k == 0) return v;
    plen = phase_len(k, i);
    v.busy = 1'b1;
    if (p == plen - 1) begin
      v.done = 1'b1;
      return v;
    end
    if (k == 1) begin
      case (p)
        1: begin v.pfr_wr = 1'b1; v.wdata = (pfr_rdata & ~32'h003F_0000) | 32'h0000_8000; end
        2: begin v.ctl_wr = 1'b1; v.fld = 2'd0; v.val = 1'b0; end
        3: begin v.ctl_wr = 1'b1; v.fld = 2'd2; v.val = 1'b1; end
        4: begin v.ctl_wr = 1'b1; v.fld = 2'd1; v.val = 1'b0; end
        default: ;
      endcase
    end else if (k == 2) begin
      case (p)
        1: begin v.ctl_wr = 1'b1; v.fld = 2'd2; v.val = 1'b1; end
        2: begin v.ctl_wr = 1'b1; v.fld = 2'd1; v.val = 1'b0; end
        default: ;
      endcase
    end else begin
      if (p == 0) begin v.ctl_wr = 1'b1; v.fld = 2'd2; v.val = 1'b0; end
      else if (p == TR + 1) begin v.ctl_wr = 1'b1; v.fld = 2'd1; v.val = 1'b1; end
      else if (has_pin(i) && p >= TR + TS + 2 && p < TR + TS + 2 + TP) v.perst = act_high(i);
    end
    return v;
  endfunction

  function automatic string tag_of(int k, int p, int i);
    if (in_reset) return "R1";
    if (k == 0) return "R10";
    if (p == phase_len(k, i) - 1) return "R9";
    if (k == 1) return (p <= 1) ? "R2" : (p == 2) ? "R3" : "R4";
    if (k == 2) return (p == 0) ? "R3" : "R4";
    if (!has_pin(i) && p >= TR + 2) return "R8";
    if (p <= TR + 1) return "R5";
    if (p < TR + TS + 2) return "R6";
    return "R7";
  endfunction

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      vec_t e;
      e = model(kind[i], pos[i], i);
      checks++;
      if (act[i] !== e) begin
        fails++;
        $display("FAIL %s inst%0d pos%0d actual=%h expected=%h",
                 tag_of(kind[i], pos[i], i), i, pos[i], act[i], e);
      end
      checks++;
      if (act[i].ctl_wr && act[i].pfr_wr) begin
        fails++;
        $display("FAIL R11 inst%0d actual two writes expected at most one", i);
      end
    end
  endtask

  task automatic advance(int i, logic a, logic d);
    if (kind[i] != 0) begin
      pos[i]++;
      if (pos[i] == phase_len(kind[i], i)) begin
        kind[i] = 0;
        pos[i]  = 0;
      end
    end else if (rst_n && a) begin
      kind[i] = (refclk_en_rb && ltssm_en_rb) ? 1 : 2;
      pos[i]  = 0;
    end else if (rst_n && d) begin
      kind[i] = 3;
      pos[i]  = 0;
    end
  endtask

  task automatic step(logic a, logic d);
    @(negedge clk);
    compare_all();
    start_assert   = a;
    start_deassert = d;
    advance(0, a, d);
    advance(1, a, d);
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) step(1'b0, 1'b0);
  endtask

  task automatic shutdown(logic rb_ref, logic rb_lt, logic [31:0] word);
    refclk_en_rb = rb_ref;
    ltssm_en_rb  = rb_lt;
    pfr_rdata    = word;
    step(1'b1, 1'b0);
    idle(8);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin kind[i] = 0; pos[i] = 0; end
    // R1: reset state
    idle(3);
    rst_n = 1'b1;
    in_reset = 1'b0;
    idle(2);
    // R2 R3 R4: live-link detection under several force words and readback mixes
    shutdown(1'b1, 1'b1, 32'hA5C3_7F21);
    shutdown(1'b1, 1'b1, 32'hFFFF_FFFF);
    shutdown(1'b1, 1'b1, 32'h0000_0000);
    shutdown(1'b1, 1'b0, 32'hFFFF_FFFF);
    shutdown(1'b0, 1'b1, 32'hFFFF_FFFF);
    shutdown(1'b0, 1'b0, 32'h1234_5678);
    // R5 R6 R7 R8 R9: bring-up timeline
    step(1'b0, 1'b1);
    idle(TR + TS + TP + 6);
    // R10: commands while busy ignored
    refclk_en_rb = 1'b1; ltssm_en_rb = 1'b1; pfr_rdata = 32'h0F0F_0F0F;
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    idle(8);
    // R10: simultaneous commands, shutdown wins
    step(1'b1, 1'b1);
    idle(8);
    // R10: shutdown command held high re-accepts only once idle
    refclk_en_rb = 1'b0;
    for (int j = 0; j < 7; j++) step(1'b1, 1'b0);
    idle(6);
    // R10: shutdown pulse during bring-up ignored
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    idle(TR + TS + TP + 6);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule